// File: doc/BRIEF.md
# Banked Scratchpad Conflict Scheduler

This block is an on-chip scratchpad built from 32 banks, each one 32-bit word wide. A front end sits in front of the banks. It takes one wavefront operation at a time, covering 64 lanes. The operation is a read, a write or an atomic add. Each lane carries its own byte address and its own data, and an active mask selects which lanes take part.

The front end accounts for the time needed to move addresses and data over an input port 64 bytes wide. It then replays the wavefront over the banks, one pass per cycle, until every active lane has been served. Within one pass a bank serves exactly one word:

- Reads of that word by several lanes share a single broadcast.
- Writes to that word collapse to the highest-numbered lane.
- Atomic adds are serialized, one lane per pass.

Read and atomic results come back in 16-lane beats, because the return port is also 64 bytes wide. The final beat reports how many cycles the whole operation took. A reference model can use this count to check conflict behaviour.

Top module: `spm_conflict_sched`

## Requirements
- R1: After reset, req_ready is 1, busy is 0 and rsp_valid is 0, and every memory word holds zero.
- R2: Each lane's byte address selects bank = addr[6:2] and word = addr[10:7]. Bits [1:0] of the address have no effect.
- R3: For a read or a write, the number of bank passes equals the largest number of distinct words addressed by active lanes in any one bank. A request with no active lanes takes zero passes.
- R4: Active lanes that read the same word of a bank are served in the same pass, and each of them receives that word's value.
- R5: An atomic add (op 2) serves one lane per pass in each bank. The pass count is the largest number of active lanes in any one bank. Lanes that hit the same word apply their adds in ascending lane order. Each lane returns the word's value from just before its own add.
- R6: When several active lanes write the same word, the word ends holding the data of the highest-numbered of those lanes.
- R7: Inactive lanes add no passes and change no memory word. They return zero in the read data.
- R8: A request is taken when req_valid and req_ready are both high at a clock edge. After that, busy is 1 and req_ready is 0 until the cycle that carries the last response beat. In the cycle after that beat, req_ready is 1 again.
- R9: Reads and atomics return 4 beats in consecutive cycles. Beat n carries lanes 16n to 16n+15, lane 16n in the lowest 32 bits, and rsp_beat equals n. A write returns a single beat whose data is zero.
- R10: The intake phase lasts 4 cycles for a read and 8 cycles for a write or atomic. The first response beat appears in cycle intake+passes+1 after the accepting edge. The last beat reports rsp_cycles = intake + passes + beats.
- R11: Op code 0 is a read, 1 is a write and 2 is an atomic add. Op code 3 behaves exactly like a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Operation code |
| req_mask | input | 64 | Active lane mask |
| req_addr | input | 704 | Per-lane byte address, 11 bits per lane, lane 0 lowest |
| req_data | input | 2048 | Per-lane write or add operand, 32 bits per lane |
| rsp_valid | output | 1 | Response beat present |
| rsp_last | output | 1 | Final beat of the response |
| rsp_beat | output | 2 | Index of the current beat |
| rsp_data | output | 512 | Sixteen lanes of result data |
| rsp_cycles | output | 7 | Total cycle count, valid on the last beat |
| busy | output | 1 | An operation is in progress |

## Verification
Every result has a fixed due cycle, counted from the edge that accepts the request:

- The first beat is due in cycle intake+passes+1.
- The last beat is due in cycle intake+passes+beats.
- req_ready returns one cycle after the last beat.

The bench computes intake, passes and beats on its own from the lane addresses and the mask. It counts falling edges after the accepting edge and samples there, so each due cycle is checked exactly and not merely as "eventually". Read data, atomic old values and write-collision winners come from a lane-ordered memory model. That model is compared against every beat at the cycle the beat is due.

// File: rtl/spm_pkg.sv
`timescale 1ns/1ps
package spm_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_ADD = 2'd2,
        OP_ALT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAKE = 2'd1,
        ST_PASS = 2'd2,
        ST_RET  = 2'd3
    } st_e;
endpackage

// File: rtl/spm_bank_pick.sv
`timescale 1ns/1ps
// Per-bank pass selector: the lowest pending lane in this bank names the word,
// then every pending lane on that word is served (only the leader for atomics).
module spm_bank_pick #(
    parameter int LANES   = 64,
    parameter int BB      = 5,
    parameter int WB      = 4,
    parameter int LI      = $clog2(LANES),
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]         pend_i,
    input  logic [LANES-1:0][BB-1:0] bank_i,
    input  logic [LANES-1:0][WB-1:0] word_i,
    input  logic                     atomic_i,
    output logic                     hit_o,
    output logic [WB-1:0]            word_o,
    output logic [LANES-1:0]         serve_o,
    output logic [LI-1:0]            last_o
);
    localparam logic [BB-1:0] MY_BANK = BB'(BANK_ID);

    logic [LANES-1:0] in_bank;
    logic [LI-1:0]    lead;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            in_bank[i] = pend_i[i] && (bank_i[i] == MY_BANK);
        end
        hit_o  = |in_bank;
        word_o = '0;
        lead   = '0;
        // descending scan so the lowest lane wins
        for (int i = LANES - 1; i >= 0; i--) begin
            if (in_bank[i]) begin
                word_o = word_i[i];
                lead   = LI'(i);
            end
        end
        serve_o = '0;
        last_o  = lead;
        // ascending scan so last_o ends on the highest served lane
        for (int i = 0; i < LANES; i++) begin
            if (in_bank[i] && (word_i[i] == word_o) && (!atomic_i || (LI'(i) == lead))) begin
                serve_o[i] = 1'b1;
                last_o     = LI'(i);
            end
        end
    end
endmodule

// File: rtl/spm_bank_mem.sv
`timescale 1ns/1ps
// One bank: a single read, write or add per cycle; read shows pre-update value.
module spm_bank_mem
    import spm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int WB    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  op_e           op_i,
    input  logic [WB-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    assign rdata_o = mem_q[idx_i];

    always_comb begin
        mem_d = mem_q;
        if (en_i) begin
            case (op_i)
                OP_WR:   mem_d[idx_i] = wdata_i;
                OP_ADD:  mem_d[idx_i] = mem_q[idx_i] + wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/spm_conflict_sched.sv
`timescale 1ns/1ps
module spm_conflict_sched
    import spm_pkg::*;
#(
    parameter int LANES      = 64,
    parameter int BANKS      = 32,
    parameter int DEPTH      = 16,
    parameter int DW         = 32,
    parameter int PORT_BYTES = 64,
    parameter int AW         = 2 + $clog2(BANKS) + $clog2(DEPTH),
    parameter int RET_LANES  = PORT_BYTES / (DW / 8),
    parameter int BTW        = (LANES / RET_LANES > 1) ? $clog2(LANES / RET_LANES) : 1,
    parameter int CW         = $clog2(2 * LANES * (DW / 8) / PORT_BYTES + LANES + LANES / RET_LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_op,
    input  logic [LANES-1:0]        req_mask,
    input  logic [LANES*AW-1:0]     req_addr,
    input  logic [LANES*DW-1:0]     req_data,
    output logic                    rsp_valid,
    output logic                    rsp_last,
    output logic [BTW-1:0]          rsp_beat,
    output logic [RET_LANES*DW-1:0] rsp_data,
    output logic [CW-1:0]           rsp_cycles,
    output logic                    busy
);
    localparam int BB     = $clog2(BANKS);
    localparam int WB     = $clog2(DEPTH);
    localparam int LI     = $clog2(LANES);
    localparam int BEATS  = LANES / RET_LANES;
    localparam int IN_RD  = LANES * (DW / 8) / PORT_BYTES;  // address only
    localparam int IN_WR  = 2 * IN_RD;                      // address plus data
    localparam int MAXC   = IN_WR + LANES + BEATS;
    localparam int PCW    = $clog2(IN_WR + 1);

    typedef struct packed {
        st_e                      st;
        op_e                      op;
        logic [LANES-1:0]         pend;
        logic [LANES-1:0][BB-1:0] bank;
        logic [LANES-1:0][WB-1:0] word;
        logic [LANES-1:0][DW-1:0] data;
        logic [LANES-1:0][DW-1:0] res;
        logic [PCW-1:0]           cnt;
        logic [BTW-1:0]           beat;
        logic [CW-1:0]            cyc;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    logic [BANKS-1:0]            b_hit;
    logic [BANKS-1:0][WB-1:0]    b_word;
    logic [BANKS-1:0][LANES-1:0] b_serve;
    logic [BANKS-1:0][LI-1:0]    b_last;
    logic [BANKS-1:0][DW-1:0]    b_rdata;
    logic [LANES-1:0]            served;
    logic [BTW-1:0]              last_beat;
    logic                        is_add;
    logic                        in_pass;

    assign is_add  = (ctx_q.op == OP_ADD);
    assign in_pass = (ctx_q.st == ST_PASS);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        spm_bank_pick #(
            .LANES(LANES), .BB(BB), .WB(WB), .LI(LI), .BANK_ID(b)
        ) u_pick (
            .pend_i   (ctx_q.pend),
            .bank_i   (ctx_q.bank),
            .word_i   (ctx_q.word),
            .atomic_i (is_add),
            .hit_o    (b_hit[b]),
            .word_o   (b_word[b]),
            .serve_o  (b_serve[b]),
            .last_o   (b_last[b])
        );

        spm_bank_mem #(
            .DEPTH(DEPTH), .DW(DW), .WB(WB)
        ) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (in_pass && b_hit[b]),
            .op_i    (ctx_q.op),
            .idx_i   (b_word[b]),
            .wdata_i (ctx_q.data[b_last[b]]),
            .rdata_o (b_rdata[b])
        );

        // R3: a bank only serves lanes still waiting
        a_r3_serve_pending: assert property (@(posedge clk) disable iff (!rst_n)
            in_pass |-> ((b_serve[b] & ~ctx_q.pend) == '0));
        // R5: atomics leave each bank with at most one lane per pass
        a_r5_atomic_single: assert property (@(posedge clk) disable iff (!rst_n)
            (in_pass && is_add) |-> $onehot0(b_serve[b]));
    end

    always_comb begin
        ctx_d  = ctx_q;
        served = '0;
        for (int b = 0; b < BANKS; b++) served = served | b_serve[b];
        last_beat = (ctx_q.op == OP_WR) ? '0 : BTW'(BEATS - 1);

        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.op   = op_e'(req_op);
                    ctx_d.pend = req_mask;
                    for (int i = 0; i < LANES; i++) begin
                        ctx_d.bank[i] = req_addr[i*AW + 2 +: BB];
                        ctx_d.word[i] = req_addr[i*AW + 2 + BB +: WB];
                        ctx_d.data[i] = req_data[i*DW +: DW];
                    end
                    ctx_d.res  = '0;
                    ctx_d.beat = '0;
                    ctx_d.cyc  = '0;
                    ctx_d.cnt  = (op_e'(req_op) == OP_WR || op_e'(req_op) == OP_ADD)
                               ? PCW'(IN_WR - 1) : PCW'(IN_RD - 1);
                    ctx_d.st   = ST_TAKE;
                end
            end
            ST_TAKE: begin
                ctx_d.cyc = ctx_q.cyc + CW'(1);
                if (ctx_q.cnt == '0) begin
                    ctx_d.st = (ctx_q.pend != '0) ? ST_PASS : ST_RET;
                end else begin
                    ctx_d.cnt = ctx_q.cnt - PCW'(1);
                end
            end
            ST_PASS: begin
                ctx_d.cyc  = ctx_q.cyc + CW'(1);
                ctx_d.pend = ctx_q.pend & ~served;
                for (int i = 0; i < LANES; i++) begin
                    if (served[i]) begin
                        ctx_d.res[i] = (ctx_q.op == OP_WR) ? '0 : b_rdata[ctx_q.bank[i]];
                    end
                end
                if ((ctx_q.pend & ~served) == '0) ctx_d.st = ST_RET;
            end
            ST_RET: begin
                ctx_d.cyc  = ctx_q.cyc + CW'(1);
                ctx_d.beat = ctx_q.beat + BTW'(1);
                if (ctx_q.beat == last_beat) ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign req_ready  = (ctx_q.st == ST_IDLE);
    assign busy       = (ctx_q.st != ST_IDLE);
    assign rsp_valid  = (ctx_q.st == ST_RET);
    assign rsp_last   = rsp_valid && (ctx_q.beat == last_beat);
    assign rsp_beat   = ctx_q.beat;
    assign rsp_cycles = rsp_last ? (ctx_q.cyc + CW'(1)) : '0;

    always_comb begin
        for (int j = 0; j < RET_LANES; j++) begin
            rsp_data[j*DW +: DW] = ctx_q.res[int'(ctx_q.beat) * RET_LANES + j];
        end
    end

    // R10: every pass retires at least one lane
    a_r10_progress: assert property (@(posedge clk) disable iff (!rst_n)
        in_pass |=> ($countones(ctx_q.pend) < $past($countones(ctx_q.pend))));
    // R3: a pass only happens while some bank has work
    a_r3_pass_has_work: assert property (@(posedge clk) disable iff (!rst_n)
        in_pass |-> (b_hit != '0));
    // R8: once busy, the block stays busy until the last beat
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rsp_last) |=> busy);
    // R10: reported count stays within the worst case
    a_r10_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> (rsp_cycles <= CW'(MAXC)));
endmodule

// File: tb/sim_spm_conflict_sched.sv
`timescale 1ns/1ps
module sim_spm_conflict_sched;
    localparam int LANES = 64, BANKS = 32, DEPTH = 16, DW = 32, AW = 11;
    localparam int RL = 16, BEATS = 4, CW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_op = '0;
    logic [LANES-1:0] req_mask = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES*DW-1:0] req_data = '0;
    logic rsp_valid, rsp_last, busy;
    logic [1:0] rsp_beat;
    logic [RL*DW-1:0] rsp_data;
    logic [CW-1:0] rsp_cycles;

    always #2.5 clk = ~clk;

    spm_conflict_sched u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_mask(req_mask), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_beat(rsp_beat),
        .rsp_data(rsp_data), .rsp_cycles(rsp_cycles), .busy(busy)
    );

    int nvec = 0, nbad = 0;
    bit done = 0;
    logic [DW-1:0] mdl [BANKS][DEPTH];
    int unsigned s_addr [LANES];
    logic [DW-1:0] s_data [LANES];

    function automatic int unsigned mk(int b, int w, int lo);
        return int'((w << 7) | (b << 2) | lo);
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [LANES-1:0] m, input string tag);
        logic [DW-1:0] er [LANES];
        int passes, in_c, nb, total, k, first_k, last_k, seen, cyc_got;
        bit busy_ok, ready_ok;
        passes = 0;
        for (int b = 0; b < BANKS; b++) begin
            bit used [DEPTH];
            int n = 0;
            for (int d = 0; d < DEPTH; d++) used[d] = 0;
            for (int i = 0; i < LANES; i++) begin
                int bi = int'((s_addr[i] >> 2) & 31);
                int wi = int'((s_addr[i] >> 7) & 15);
                if (m[i] && bi == b) begin
                    if (op == 2) n++;
                    else if (!used[wi]) begin used[wi] = 1; n++; end
                end
            end
            if (n > passes) passes = n;
        end
        for (int i = 0; i < LANES; i++) begin
            int bi = int'((s_addr[i] >> 2) & 31);
            int wi = int'((s_addr[i] >> 7) & 15);
            er[i] = '0;
            if (m[i]) begin
                case (op)
                    2'd1: mdl[bi][wi] = s_data[i];
                    2'd2: begin er[i] = mdl[bi][wi]; mdl[bi][wi] = mdl[bi][wi] + s_data[i]; end
                    default: er[i] = mdl[bi][wi];
                endcase
            end
        end
        in_c  = (op == 1 || op == 2) ? 8 : 4;
        nb    = (op == 1) ? 1 : BEATS;
        total = in_c + passes + nb;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_mask = m;
        for (int i = 0; i < LANES; i++) begin
            req_addr[i*AW +: AW] = AW'(s_addr[i]);
            req_data[i*DW +: DW] = s_data[i];
        end
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k = 1; first_k = 0; last_k = 0; seen = 0; cyc_got = -1; busy_ok = 1;
        while (last_k == 0 && k <= total + 4) begin
            if (!busy || req_ready) busy_ok = 0;
            if (rsp_valid) begin
                bit ok = 1;
                int bad_l = 0;
                if (first_k == 0) first_k = k;
                chk(int'(rsp_beat) == seen, "R9", "beat index", rsp_beat, seen);
                for (int l = 0; l < RL; l++) begin
                    if (ok && rsp_data[l*DW +: DW] !== er[int'(rsp_beat)*RL + l]) begin
                        ok = 0; bad_l = l;
                    end
                end
                chk(ok, tag, $sformatf("R9 data beat %0d lane %0d", rsp_beat, bad_l),
                    rsp_data[bad_l*DW +: DW], er[int'(rsp_beat)*RL + bad_l]);
                if (rsp_last) begin last_k = k; cyc_got = int'(rsp_cycles); end
                seen++;
            end
            @(negedge clk);
            k++;
        end
        ready_ok = req_ready && !busy;
        chk(first_k == in_c + passes + 1, "R10", {tag, " first beat cycle"}, first_k, in_c + passes + 1);
        chk(cyc_got == total, "R10", {tag, " rsp_cycles"}, cyc_got, total);
        chk(last_k == total && seen == nb, "R9", {tag, " beat count"}, seen, nb);
        chk(busy_ok, "R8", {tag, " busy/ready while working"}, busy_ok, 1);
        chk(ready_ok, "R8", {tag, " ready after last beat"}, ready_ok, 1);
    endtask

    initial begin
        for (int b = 0; b < BANKS; b++) for (int d = 0; d < DEPTH; d++) mdl[b][d] = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy && !rsp_valid, "R1", "idle after reset", {req_ready, busy, rsp_valid}, 3'b100);

        // R1 R2: linear read of zeroed memory, two words per bank
        for (int i = 0; i < LANES; i++) begin s_addr[i] = mk(i % 32, i / 32, 0); s_data[i] = '0; end
        run(2'd0, '1, "R1");
        // R3: linear write then read back
        for (int i = 0; i < LANES; i++) s_data[i] = DW'(i * 3 + 1);
        run(2'd1, '1, "R3");
        run(2'd0, '1, "R3");
        // R4: broadcast read of one word
        s_addr[0] = mk(5, 3, 0); s_data[0] = 32'h0000_abcd;
        run(2'd1, 64'h1, "R4");
        for (int i = 0; i < LANES; i++) s_addr[i] = mk(5, 3, i % 4);
        run(2'd0, '1, "R4");
        // R2 R3: one bank, sixteen words, byte offsets vary
        for (int i = 0; i < LANES; i++) s_addr[i] = mk(7, i % 16, i % 4);
        run(2'd0, '1, "R2");
        // R6: write collision, highest lane wins
        for (int i = 0; i < LANES; i++) begin s_addr[i] = mk(9, 2, 0); s_data[i] = DW'(1000 + i); end
        run(2'd1, '1, "R6");
        run(2'd0, 64'h1, "R6");
        // R5: 64 atomics on one word
        for (int i = 0; i < LANES; i++) s_data[i] = DW'(i + 1);
        run(2'd2, '1, "R5");
        run(2'd0, 64'h8000_0000_0000_0001, "R5");
        // R5: spread atomics, partial mask
        for (int i = 0; i < LANES; i++) begin s_addr[i] = mk(i % 4, i % 3, 0); s_data[i] = DW'(7 * i); end
        run(2'd2, 64'hf0f0_3c3c_aaaa_5555, "R5");
        // R7: empty write leaves memory alone
        for (int i = 0; i < LANES; i++) begin s_addr[i] = mk(i % 32, i / 32, 0); s_data[i] = 32'hdead_beef; end
        run(2'd1, '0, "R7");
        run(2'd0, '1, "R7");
        // R7: inactive lanes with conflicting addresses add no passes
        for (int i = 32; i < LANES; i++) s_addr[i] = mk(0, i % 16, 0);
        run(2'd0, 64'h0000_0000_ffff_ffff, "R7");
        // R11: op 3 acts as a read
        run(2'd3, '1, "R11");
        // R3: random sweep
        for (int t = 0; t < 150; t++) begin
            int br = (t % 2 == 0) ? 4 : 32;
            logic [LANES-1:0] m = {$urandom, $urandom};
            for (int i = 0; i < LANES; i++) begin
                s_addr[i] = mk(int'($urandom % br), int'($urandom % 4), int'($urandom % 4));
                s_data[i] = $urandom;
            end
            run(2'($urandom % 3), m, "R3");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nvec++; nbad++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule